// File: doc/BRIEF.md
# Soft Reset and Clock-Gate Control Word

This block holds one control word for a peripheral. The word carries a soft-reset bit, a clock-gate bit and a field of ordinary configuration bits. Software can overwrite the whole word at a base address. It can also use a set alias, where every written one sets the matching bit, or a clear alias, where every written one clears the matching bit. The block drives a synchronous reset output and a clock-enable output for the rest of the peripheral.

Setting the soft-reset bit puts the peripheral into reset. A fixed number of cycles later, modelling the time needed to drain activity, the block closes the clock gate itself. Software polls the gate bit until it reads one. It then clears the soft-reset bit and clears the gate bit, and polls until the gate reads zero. While reset is held, the configuration field reads back as its reset value and ignores writes. Once the gate has closed during reset, software cannot open it until reset has been released.

Top module: `softrst_gate_ctrl`

## Requirements
- R1: A write with `wr_sel`=0 (base) replaces the whole word. `rd_data` returns the word: bit DATA_W-1 is soft reset, bit DATA_W-2 is the clock gate, and bits DATA_W-3..0 are the configuration field.
- R2: `wr_sel`=1 (set alias) sets each bit written as one. `wr_sel`=2 (clear alias) clears each bit written as one. `wr_sel`=3 leaves the word unchanged.
- R3: After `rst_n` is deasserted, `rd_data` reads soft reset 0, gate 0 and configuration field GEN_INIT. `core_rst` is 0 and `core_clk_en` is 1.
- R4: `core_rst` equals the soft-reset bit and changes in the cycle after the write that changes that bit.
- R5: Take the first cycle in which soft reset reads one with the gate at zero. The gate bit reads one exactly DRAIN_CYCLES cycles later, provided soft reset stays one throughout. If soft reset is cleared before then, the gate does not assert.
- R6: While soft reset and gate are both one, writes that clear the gate have no effect.
- R7: Clearing soft reset while the gate is one releases `core_rst`, but the gate stays one and `core_clk_en` stays 0.
- R8: `core_clk_en` is the inverse of the gate bit. With soft reset at zero, clearing the gate raises `core_clk_en` in the next cycle. Setting the gate lowers it in the next cycle.
- R9: While soft reset is one, the configuration field reads GEN_INIT and ignores writes. After release, it still holds GEN_INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Address select: 0 base, 1 set alias, 2 clear alias, 3 none |
| wr_data | input | DATA_W | Write data or bit mask |
| rd_data | output | DATA_W | Current control word |
| core_rst | output | 1 | Synchronous reset to the peripheral |
| core_clk_en | output | 1 | Clock enable to the peripheral (gate open) |

## Verification
The bench counts the polling cycles between setting soft reset and seeing the gate close. A timer that is off by one gives a count of DRAIN_CYCLES plus or minus one. It starts a reset, then aborts it before the drain finishes. A timer that fails to clear on abort would close the gate later with no reset active. It tries to open the gate while reset is still held, and releases reset with the gate closed. A design that let the gate follow the write would restart the clock inside reset, or would open it on release. Reading the configuration field in the very first cycle of reset catches a design that only clears the field a cycle late and does not mask the read.

// File: rtl/srg_pkg.sv
package srg_pkg;
  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_SET  = 2'd1,
    SEL_CLR  = 2'd2,
    SEL_NONE = 2'd3
  } wr_sel_e;

  // One bit of the control word after a write through the given address.
  function automatic logic alias_bit(logic old_b, logic d_b, logic [1:0] sel);
    case (sel)
      SEL_BASE: alias_bit = d_b;
      SEL_SET:  alias_bit = old_b | d_b;
      SEL_CLR:  alias_bit = old_b & ~d_b;
      default:  alias_bit = old_b;
    endcase
  endfunction
endpackage

// File: rtl/srg_word_update.sv
module srg_word_update #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] cur_word,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] next_word
);
  import srg_pkg::*;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    always_comb begin
      if (wr_en) next_word[b] = alias_bit(cur_word[b], wr_data[b], wr_sel);
      else       next_word[b] = cur_word[b];
    end
  end
endmodule

// File: rtl/srg_drain_timer.sv
module srg_drain_timer #(
  parameter int DRAIN_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic hit
);
  localparam int CW = $clog2(DRAIN_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DRAIN_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign hit = arm && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !arm) cnt_q <= '0;
    else if (!hit)      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/softrst_gate_ctrl.sv
module softrst_gate_ctrl #(
  parameter int                DATA_W       = 32,
  parameter int                DRAIN_CYCLES = 4,
  parameter logic [DATA_W-3:0] GEN_INIT     = 'h5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              core_rst,
  output logic              core_clk_en
);
  localparam int SRST_POS = DATA_W - 1;
  localparam int GATE_POS = DATA_W - 2;
  localparam int GEN_W    = DATA_W - 2;

  logic             srst_q, gate_q;
  logic [GEN_W-1:0] gen_q;
  logic [DATA_W-1:0] word_cur, word_wr;
  logic             drain_hit;   // timer expiry: gate closes next cycle
  logic             gate_hold;   // gate locked closed while reset is held

  assign word_cur  = {srst_q, gate_q, gen_q};
  assign gate_hold = srst_q & gate_q;

  srg_word_update #(.DATA_W(DATA_W)) u_upd (
    .cur_word (word_cur),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .next_word(word_wr)
  );

  srg_drain_timer #(.DRAIN_CYCLES(DRAIN_CYCLES)) u_drain (
    .clk  (clk),
    .rst_n(rst_n),
    .arm  (srst_q & ~gate_q),
    .hit  (drain_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srst_q <= 1'b0;
      gate_q <= 1'b0;
      gen_q  <= GEN_INIT;
    end else begin
      srst_q <= word_wr[SRST_POS];
      gate_q <= word_wr[GATE_POS] | drain_hit | gate_hold;
      gen_q  <= srst_q ? GEN_INIT : word_wr[GEN_W-1:0];
    end
  end

  assign rd_data     = {srst_q, gate_q, (srst_q ? GEN_INIT : gen_q)};
  assign core_rst    = srst_q;
  assign core_clk_en = ~gate_q;
endmodule

// File: rtl/srg_checker.sv
module srg_checker #(
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-3:0] GEN_INIT = 'h5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [DATA_W-1:0] rd_data,
  input logic              core_rst,
  input logic              core_clk_en,
  input logic              drain_hit
);
  a_r6_gate_held: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst && !core_clk_en) |=> !core_clk_en);

  a_r7_release_keeps_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(core_rst) && $past(!core_clk_en)) |-> !core_clk_en);

  a_r9_field_masked: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> (rd_data[DATA_W-3:0] == GEN_INIT));

  a_r5_drain_closes_gate: assert property (@(posedge clk) disable iff (!rst_n)
    drain_hit |=> (!core_clk_en && rd_data[DATA_W-2]));

  a_r5_drain_only_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    drain_hit |-> core_rst);

  a_r2_idle_select: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3 && !drain_hit) |=> $stable(rd_data));
endmodule

bind softrst_gate_ctrl srg_checker #(.DATA_W(DATA_W), .GEN_INIT(GEN_INIT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .rd_data    (rd_data),
  .core_rst   (core_rst),
  .core_clk_en(core_clk_en),
  .drain_hit  (drain_hit)
);

// File: tb/sim_softrst_gate_ctrl.sv
module sim_softrst_gate_ctrl;
  localparam int DW = 32;
  localparam int DRAIN = 4;
  localparam logic [31:0] INIT = 32'h0000_0005;
  localparam int NV = 8;
  // {sel, data, expected read}; starts from the reset state
  localparam logic [65:0] VEC [NV] = '{
    {2'd0, 32'h0000_1234, 32'h0000_1234},
    {2'd1, 32'h0000_0F00, 32'h0000_1F34},
    {2'd2, 32'h0000_0034, 32'h0000_1F00},
    {2'd3, 32'hFFFF_FFFF, 32'h0000_1F00},
    {2'd2, 32'h0000_1F00, 32'h0000_0000},
    {2'd1, 32'h4000_0000, 32'h4000_0000},
    {2'd2, 32'h4000_0000, 32'h0000_0000},
    {2'd0, 32'h0000_00AA, 32'h0000_00AA}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic core_rst, core_clk_en;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  softrst_gate_ctrl #(.DATA_W(DW), .DRAIN_CYCLES(DRAIN), .GEN_INIT(30'h5)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_data(rd_data), .core_rst(core_rst), .core_clk_en(core_clk_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 word", rd_data, INIT);
    chk("R3 core_rst", {31'b0, core_rst}, 32'd0);
    chk("R3 clk_en", {31'b0, core_clk_en}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][65:64], VEC[i][63:32]);
      chk($sformatf("R1/R2/R8 vector %0d", i), rd_data, VEC[i][31:0]);
    end

    // R4/R9: set reset; field masked at once
    wr(2'd1, 32'h8000_0000);
    chk("R4 core_rst set", {31'b0, core_rst}, 32'd1);
    chk("R9 masked first cycle", rd_data, 32'h8000_0005);
    // R5: poll for the gate
    n = 0;
    while (!rd_data[30] && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk("R5 drain cycles", n, DRAIN);
    chk("R8 clk_en gated", {31'b0, core_clk_en}, 32'd0);
    // R9: field write ignored in reset
    wr(2'd0, 32'hC000_00FF);
    chk("R9 write ignored", rd_data, 32'hC000_0005);
    // R6: cannot open gate in reset
    wr(2'd2, 32'h4000_0000);
    chk("R6 gate held", rd_data, 32'hC000_0005);
    // R7: release reset, gate stays
    wr(2'd2, 32'h8000_0000);
    chk("R7 word", rd_data, 32'h4000_0005);
    chk("R7 core_rst", {31'b0, core_rst}, 32'd0);
    chk("R7 clk_en", {31'b0, core_clk_en}, 32'd0);
    // R8: open gate
    wr(2'd2, 32'h4000_0000);
    chk("R8 reopen", rd_data, 32'h0000_0005);
    chk("R8 clk_en", {31'b0, core_clk_en}, 32'd1);

    // R5: aborted reset never closes the gate
    wr(2'd1, 32'h8000_0000);
    wr(2'd2, 32'h8000_0000);
    repeat (8) @(negedge clk);
    chk("R5 abort no gate", rd_data, 32'h0000_0005);

    // R5: reset entered through base address also drains
    wr(2'd0, 32'h8000_0000);
    n = 0;
    while (!rd_data[30] && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk("R5 base-entry drain", n, DRAIN);
    // R2: idle select during reset changes nothing
    wr(2'd3, 32'h0000_0000);
    chk("R2 idle select", rd_data, 32'hC000_0005);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule